// File: doc/BRIEF.md
# Video Vertical Sync and Field Extractor

This block receives a one-bit composite sync signal that has already been sliced and is active low, sampled on a system clock. It measures the width of every low pulse and sorts each pulse into one of three kinds: equalizing, line sync or broad. From the sequence of pulses it produces four registered outputs. The first is a clean copy of the composite sync. The second is an active-low vertical sync pulse of fixed length. The third is a flag that gives the parity of the current field. The fourth is an active-low gate that covers the back porch after each line sync.

Vertical sync normally starts at the end of the first broad pulse that follows a run of half-line-spaced equalizing pulses. If the input stays low for too long, a timeout starts vertical sync anyway, so non-standard inputs still produce one. Field parity comes from the distance between the last full-line sync and the first equalizing pulse. Every duration is a parameter counted in clock cycles. Edges on `sync_n_in` are counted from the first clock edge that captures them.

Top module: `vsync_field_extract`

## Requirements
- R1: `csync_n` equals the value `sync_n_in` had at the previous rising clock edge.
- R2: A low pulse of W cycles counts as equalizing when W < EQ_MAX, as line sync when EQ_MAX <= W <= LINE_MAX, and as broad when W > LINE_MAX.
- R3: A run of equalizing pulses arms the block once it holds at least PRE_EQ_MIN pulses. The first pulse of a run may have any spacing; each later pulse must follow the previous equalizing pulse with a fall-to-fall spacing below 3*LINE_CYC/4. While armed, the rising input edge that ends a broad pulse makes `vsync_n` fall 2 cycles later.
- R4: A broad pulse that follows fewer than PRE_EQ_MIN equalizing pulses in such a run starts no vertical sync.
- R5: If the input stays low for DEF_DLY cycles, `vsync_n` falls DEF_DLY+1 cycles after the falling input edge. A low pulse of DEF_DLY-1 cycles does not trigger this.
- R6: `vsync_n` stays low for exactly VS_W cycles, whether the trigger was normal or the timeout.
- R7: Any trigger that arrives while `vsync_n` is low is ignored.
- R8: On a normal trigger, `field_odd` is loaded in the cycle `vsync_n` falls. It becomes 1 if the spacing from the last line sync fall to the first equalizing fall is at least 3*LINE_CYC/4, and 0 otherwise. A timeout trigger leaves it unchanged.
- R9: `field_odd` changes only in the cycle in which `vsync_n` falls.
- R10: After the rising input edge that ends a line sync pulse, `bp_gate_n` goes low BP_DLY+2 cycles later and stays low for BP_W cycles.
- R11: Equalizing and broad pulses never start `bp_gate_n`.
- R12: While `rst` is high, and after it is released with the input idle high, `csync_n`, `vsync_n` and `bp_gate_n` are 1 and `field_odd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_n_in | input | 1 | Sliced composite sync, active low |
| csync_n | output | 1 | Registered composite sync |
| vsync_n | output | 1 | Vertical sync pulse, active low |
| field_odd | output | 1 | 1 in odd fields, 0 in even fields |
| bp_gate_n | output | 1 | Back porch gate, active low |

## Verification
Suppose the equalizing run counter or the stored parity candidate is wrong. The port then shows a vertical pulse that starts at the wrong edge, or is missing, or a field flag that is inverted. The bench sees this within two cycles of the end of the first broad pulse. A wrong width or spacing classification shows up as a back porch gate that is missing or extra after the very next pulse. A wrong vertical countdown shows up as a wrong pulse length when `vsync_n` rises. A broken timeout or busy guard shows up DEF_DLY+1 cycles into a long low, as a fall where none is expected or as no fall where one is expected.

// File: rtl/vsx_pkg.sv
package vsx_pkg;
  typedef enum logic [1:0] {
    PK_NONE  = 2'd0,
    PK_EQ    = 2'd1,
    PK_LINE  = 2'd2,
    PK_BROAD = 2'd3
  } pulse_kind_t;
endpackage

// File: rtl/vsx_pulse_meas.sv
module vsx_pulse_meas
  import vsx_pkg::*;
#(
  parameter int CW       = 11,
  parameter int EQ_MAX   = 8,
  parameter int LINE_MAX = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync_n_in,
  output logic          cur_n,
  output logic          prev_n,
  output logic [CW-1:0] low_len,
  output logic [CW-1:0] gap,
  output pulse_kind_t   kind
);
  localparam logic [CW-1:0] EQ_LIM = CW'(EQ_MAX);
  localparam logic [CW-1:0] LN_LIM = CW'(LINE_MAX);
  localparam logic [CW-1:0] SAT    = '1;

  logic [CW-1:0] gap_cnt;
  logic          fall_stb;
  logic          rise_stb;

  assign fall_stb = !cur_n && prev_n;
  assign rise_stb = cur_n && !prev_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_n   <= 1'b1;
      prev_n  <= 1'b1;
      low_len <= '0;
      gap     <= '0;
      gap_cnt <= '0;
    end else begin
      cur_n  <= sync_n_in;
      prev_n <= cur_n;
      if (!cur_n) begin
        if (prev_n)            low_len <= CW'(1);
        else if (low_len != SAT) low_len <= low_len + CW'(1);
      end
      if (fall_stb) begin
        gap     <= gap_cnt;
        gap_cnt <= CW'(1);
      end else if (gap_cnt != SAT) begin
        gap_cnt <= gap_cnt + CW'(1);
      end
    end
  end

  always_comb begin
    if (!rise_stb)            kind = PK_NONE;
    else if (low_len < EQ_LIM)  kind = PK_EQ;
    else if (low_len <= LN_LIM) kind = PK_LINE;
    else                      kind = PK_BROAD;
  end

  assert_csync_follow_R1: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> cur_n == $past(sync_n_in));
endmodule

// File: rtl/vsx_vert_ctl.sv
module vsx_vert_ctl
  import vsx_pkg::*;
#(
  parameter int CW         = 11,
  parameter int LINE_CYC   = 128,
  parameter int PRE_EQ_MIN = 3,
  parameter int DEF_DLY    = 124,
  parameter int VS_W       = 460
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cur_n,
  input  logic          prev_n,
  input  logic [CW-1:0] low_len,
  input  logic [CW-1:0] gap,
  input  pulse_kind_t   kind,
  output logic          vsync_n,
  output logic          field_odd
);
  localparam int            RW       = $clog2(PRE_EQ_MIN + 1) + 1;
  localparam logic [CW-1:0] HALF_THR = CW'((LINE_CYC * 3) / 4);
  localparam logic [CW-1:0] DEF_M1   = CW'(DEF_DLY - 1);
  localparam logic [CW-1:0] VS_LOAD  = CW'(VS_W - 1);
  localparam logic [RW-1:0] RUN_MIN  = RW'(PRE_EQ_MIN);

  pulse_kind_t   last_kind;
  logic [RW-1:0] eq_run;
  logic          par_cand;
  logic [CW-1:0] vs_cnt;
  logic          trig_norm, trig_def, busy, fire;

  assign busy      = !vsync_n;
  assign trig_norm = (kind == PK_BROAD) && (eq_run >= RUN_MIN);
  assign trig_def  = !cur_n && !prev_n && (low_len == DEF_M1);
  assign fire      = (trig_norm || trig_def) && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_kind <= PK_NONE;
      eq_run    <= '0;
      par_cand  <= 1'b1;
    end else if (kind != PK_NONE) begin
      last_kind <= kind;
      if (kind == PK_EQ) begin
        if (last_kind == PK_LINE) begin
          eq_run   <= RW'(1);
          par_cand <= (gap >= HALF_THR);
        end else if (last_kind == PK_EQ && gap < HALF_THR) begin
          if (eq_run < RUN_MIN) eq_run <= eq_run + RW'(1);
        end else begin
          eq_run <= RW'(1);
        end
      end else begin
        eq_run <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vsync_n   <= 1'b1;
      field_odd <= 1'b1;
      vs_cnt    <= '0;
    end else if (fire) begin
      vsync_n <= 1'b0;
      vs_cnt  <= VS_LOAD;
      if (trig_norm) field_odd <= par_cand;
    end else if (busy) begin
      if (vs_cnt != '0) vs_cnt  <= vs_cnt - CW'(1);
      else              vsync_n <= 1'b1;
    end
  end

  assert_vs_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!vsync_n && vs_cnt != '0) |=> !vsync_n);
  assert_no_retrigger_R7: assert property (@(posedge clk) disable iff (rst)
    (!vsync_n && vs_cnt != '0) |=> vs_cnt == $past(vs_cnt) - CW'(1));
  assert_field_at_vs_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(field_odd) |-> $fell(vsync_n));
endmodule

// File: rtl/vsx_porch_gate.sv
module vsx_porch_gate
  import vsx_pkg::*;
#(
  parameter int CW     = 11,
  parameter int BP_DLY = 1,
  parameter int BP_W   = 7
) (
  input  logic        clk,
  input  logic        rst,
  input  pulse_kind_t kind,
  output logic        bp_gate_n
);
  localparam logic [CW-1:0] TOT  = CW'(BP_DLY + BP_W);
  localparam logic [CW-1:0] WLIM = CW'(BP_W);

  logic [CW-1:0] bp_cnt, nxt;

  always_comb begin
    if (kind == PK_LINE)    nxt = TOT;
    else if (bp_cnt != '0)  nxt = bp_cnt - CW'(1);
    else                    nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bp_cnt    <= '0;
      bp_gate_n <= 1'b1;
    end else begin
      bp_cnt    <= nxt;
      bp_gate_n <= !((nxt != '0) && (nxt <= WLIM));
    end
  end

  assert_gate_line_only_R11: assert property (@(posedge clk) disable iff (rst)
    (kind != PK_LINE && bp_cnt == '0) |=> bp_gate_n);
endmodule

// File: rtl/vsync_field_extract.sv
module vsync_field_extract
  import vsx_pkg::*;
#(
  parameter int LINE_CYC   = 128,
  parameter int EQ_MAX     = 8,
  parameter int LINE_MAX   = 20,
  parameter int PRE_EQ_MIN = 3,
  parameter int DEF_DLY    = 124,
  parameter int VS_W       = 460,
  parameter int BP_DLY     = 1,
  parameter int BP_W       = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_n_in,
  output logic csync_n,
  output logic vsync_n,
  output logic field_odd,
  output logic bp_gate_n
);
  localparam int CW = $clog2(VS_W + 2 * LINE_CYC + DEF_DLY) + 1;

  logic          prev_n;
  logic [CW-1:0] low_len, gap;
  pulse_kind_t   kind;

  vsx_pulse_meas #(.CW(CW), .EQ_MAX(EQ_MAX), .LINE_MAX(LINE_MAX)) u_meas (
    .clk(clk), .rst(rst), .sync_n_in(sync_n_in),
    .cur_n(csync_n), .prev_n(prev_n), .low_len(low_len), .gap(gap), .kind(kind)
  );

  vsx_vert_ctl #(.CW(CW), .LINE_CYC(LINE_CYC), .PRE_EQ_MIN(PRE_EQ_MIN),
                 .DEF_DLY(DEF_DLY), .VS_W(VS_W)) u_vert (
    .clk(clk), .rst(rst), .cur_n(csync_n), .prev_n(prev_n),
    .low_len(low_len), .gap(gap), .kind(kind),
    .vsync_n(vsync_n), .field_odd(field_odd)
  );

  vsx_porch_gate #(.CW(CW), .BP_DLY(BP_DLY), .BP_W(BP_W)) u_porch (
    .clk(clk), .rst(rst), .kind(kind), .bp_gate_n(bp_gate_n)
  );
endmodule

// File: tb/sim_vsync_field_extract.sv
module sim_vsync_field_extract;
  localparam int CLK_PERIOD = 10;
  localparam int LINE_CYC   = 128;
  localparam int HALF       = LINE_CYC / 2;
  localparam int HALF_THR   = (LINE_CYC * 3) / 4;
  localparam int EQ_MAX     = 8;
  localparam int LINE_MAX   = 20;
  localparam int PRE_EQ_MIN = 3;
  localparam int DEF_DLY    = 124;
  localparam int VS_W       = 460;
  localparam int BP_DLY     = 1;
  localparam int BP_W       = 7;
  localparam int K_EQ = 1, K_LINE = 2, K_BROAD = 3;

  logic clk = 1'b0, rst = 1'b1, sin = 1'b1;
  logic csync_n, vsync_n, field_odd, bp_gate_n;
  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;

  vsync_field_extract #(.LINE_CYC(LINE_CYC), .EQ_MAX(EQ_MAX), .LINE_MAX(LINE_MAX),
    .PRE_EQ_MIN(PRE_EQ_MIN), .DEF_DLY(DEF_DLY), .VS_W(VS_W), .BP_DLY(BP_DLY),
    .BP_W(BP_W)) u0 (
    .clk(clk), .rst(rst), .sync_n_in(sin), .csync_n(csync_n), .vsync_n(vsync_n),
    .field_odd(field_odd), .bp_gate_n(bp_gate_n));

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int classify(int w);
    if (w < EQ_MAX) return K_EQ;
    if (w <= LINE_MAX) return K_LINE;
    return K_BROAD;
  endfunction

  // reference state built from the requirements
  int exp_vs_e = -1, exp_bp_e = -1, last_vs_start = -100000;
  bit exp_field = 1, cur_field = 1, par_cand = 1;
  string vs_tag = "R3";
  int exp_vs_cnt = 0, line_cnt = 0, last_fall_c = -100000, last_kind = 0, eq_run = 0;

  // monitor
  logic sin_at_edge = 1'b1;
  logic prev_vs = 1'b1, prev_bp = 1'b1;
  int vs_start = 0, bp_start = 0, vs_falls = 0, bp_falls = 0;
  always @(posedge clk) sin_at_edge <= sin;
  always @(negedge clk) begin
    if (!rst) begin
      chk(csync_n == sin_at_edge, "R1 csync", csync_n, sin_at_edge);
      if (prev_vs && !vsync_n) begin
        vs_falls++; vs_start = cyc;
        chk(cyc == exp_vs_e, {vs_tag, " vsync start"}, cyc, exp_vs_e);
        chk(field_odd == exp_field, "R8 field flag", field_odd, exp_field);
        exp_vs_e = -1;
      end
      if (!prev_vs && vsync_n)
        chk(cyc - vs_start == VS_W, "R6 vsync width", cyc - vs_start, VS_W);
      if (prev_bp && !bp_gate_n) begin
        bp_falls++; bp_start = cyc;
        chk(cyc == exp_bp_e, "R10/R11 gate start", cyc, exp_bp_e);
      end
      if (!prev_bp && bp_gate_n)
        chk(cyc - bp_start == BP_W, "R10 gate width", cyc - bp_start, BP_W);
      prev_vs = vsync_n;
      prev_bp = bp_gate_n;
    end
  end

  // one low pulse followed by a high gap, caller sits at a negedge
  task automatic pulse(int low, int high);
    int k, gap, fall_c, rise_c;
    fall_c = cyc;
    sin = 1'b0;
    k = classify(low);
    gap = fall_c - last_fall_c;
    last_fall_c = fall_c;
    if (low >= DEF_DLY && fall_c + 1 + DEF_DLY > last_vs_start + VS_W) begin
      exp_vs_e = fall_c + 1 + DEF_DLY; exp_field = cur_field; vs_tag = "R5";
      last_vs_start = exp_vs_e; exp_vs_cnt++;
    end
    repeat (low) @(negedge clk);
    rise_c = cyc;
    sin = 1'b1;
    if (k == K_EQ) begin
      if (last_kind == K_LINE) begin eq_run = 1; par_cand = (gap >= HALF_THR); end
      else if (last_kind == K_EQ && gap < HALF_THR) eq_run++;
      else eq_run = 1;
      exp_bp_e = -1;
    end else begin
      if (k == K_BROAD && eq_run >= PRE_EQ_MIN && rise_c + 2 > last_vs_start + VS_W) begin
        exp_vs_e = rise_c + 2; exp_field = par_cand; cur_field = par_cand; vs_tag = "R3";
        last_vs_start = exp_vs_e; exp_vs_cnt++;
      end
      eq_run = 0;
      if (k == K_LINE) begin exp_bp_e = rise_c + 2 + BP_DLY; line_cnt++; end
      else exp_bp_e = -1;
    end
    last_kind = k;
    repeat (high) @(negedge clk);
  endtask

  task automatic lines(int n);
    for (int i = 0; i < n; i++) begin
      int w = 9 + $urandom_range(0, 2) - 1;
      pulse(w, LINE_CYC - w);
    end
  endtask

  task automatic vert(bit odd, int n_pre);
    int w;
    if (!odd) begin w = 9; pulse(w, HALF - w); end
    for (int i = 0; i < n_pre; i++) begin w = 4 + $urandom_range(0, 2); pulse(w, HALF - w); end
    for (int i = 0; i < 6; i++) pulse(54, HALF - 54);
    for (int i = 0; i < 6; i++) begin w = 4 + $urandom_range(0, 2); pulse(w, HALF - w); end
  endtask

  task automatic tally(string req);
    chk(vs_falls == exp_vs_cnt, {req, " vsync count"}, vs_falls, exp_vs_cnt);
    chk(bp_falls == line_cnt, "R11 gate count", bp_falls, line_cnt);
  endtask

  initial begin
    void'($urandom(32'd4451));
    repeat (4) @(negedge clk);
    chk(csync_n && vsync_n && bp_gate_n, "R12 outputs idle", {csync_n, vsync_n, bp_gate_n}, 7);
    chk(field_odd == 1'b1, "R12 field", field_odd, 1);
    rst = 1'b0;
    @(negedge clk);
    chk(csync_n && vsync_n && bp_gate_n && field_odd, "R12 after release",
        {csync_n, vsync_n, bp_gate_n, field_odd}, 15);
    // directed: odd, even, odd
    lines(6); vert(1, 6); lines(6); tally("R3 odd");
    vert(0, 6); lines(6); tally("R3 even");
    chk(field_odd == 1'b0, "R8 even field held", field_odd, 0);
    vert(1, 6); lines(6); tally("R3 odd again");
    // R4: too short a pre-equalizing run
    vert(1, PRE_EQ_MIN - 1); lines(6); tally("R4");
    // R2 width boundaries
    pulse(EQ_MAX, LINE_CYC - EQ_MAX);
    pulse(LINE_MAX, LINE_CYC - LINE_MAX);
    pulse(EQ_MAX - 1, LINE_CYC - EQ_MAX + 1);
    pulse(LINE_MAX + 1, LINE_CYC - LINE_MAX - 1);
    lines(2); tally("R2 boundaries");
    // R5 timeout boundary: one cycle short, then exact
    pulse(DEF_DLY - 1, 60); lines(2); tally("R5 short low");
    pulse(DEF_DLY, 60); lines(1);
    // R7: second long low while vertical sync active
    pulse(DEF_DLY + 16, 40); lines(6); tally("R5/R7 timeout");
    chk(field_odd == 1'b1, "R8 timeout keeps field", field_odd, 1);
    // random fields
    for (int f = 0; f < 30; f++) begin
      lines(3 + $urandom_range(0, 5));
      vert($urandom_range(0, 1) == 1, PRE_EQ_MIN + $urandom_range(0, 3));
      if ($urandom_range(0, 5) == 0) begin lines(1); pulse(DEF_DLY + $urandom_range(0, 20), 50); end
    end
    lines(6); tally("R3 random");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule